// File: doc/BRIEF.md
# Region-Based Address Space Firewall

This block sits in front of a memory and judges every transaction presented on its check port. A transaction carries an address, a 3-bit compartment ID, a secure flag, a privileged flag and a read/write direction. The block compares it against a set of configurable base regions. Each base region can hold two nested subregions, A and B. One cycle after a transaction is presented, the block returns a grant or a deny.

A word-addressed configuration port programs the regions. Each write on this port carries the initiator's compartment ID and its secure and privileged flags. Only the trusted initiator may program base regions and the global words. A subregion's configuration can also be handed to one other compartment. The block records the first illegal transaction or rejected configuration write and raises a flag, which software clears by writing ones.

Top module: `addr_region_firewall`

Configuration map (8-bit word address): block `cfg_addr[7:4]` = 0 holds the global words. Word 0 is control (bit0 global lock). Word 1 is status (bit0 illegal access, bit1 configuration error). Word 2 is the write-one-to-clear register for the two status bits. Word 3 is capture info (bits[2:0] CID, bit4 secure, bit5 privileged, bit6 write). Word 4 is the captured address. Block r+1 belongs to region r. Its word 0 is the base configuration (bit0 enable, bit1 secure, bits[15:8] privilege list). Words 1 and 2 are start and end. Word 3 holds the read list in bits[7:0] and the write list in bits[23:16]. Words 4..7 are subregion A and words 8..11 are subregion B, each laid out as: configuration (bit0 enable, bit1 secure, bit2 privileged-only, bit3 read, bit4 write, bit5 lock, bits[10:8] CID), start, end, and delegation (bit0 enable, bits[6:4] CID). A write is trusted when it is secure and its CID equals `TRUST_CID`.

## Requirements
- R1: After reset all regions are disabled and both flags are 0. A transaction whose address lies in no enabled base region is denied.
- R2: `res_valid` is high exactly in the cycle after `chk_valid`, and `res_grant` carries the decision for that transaction.
- R3: In a base region, a read is granted only if the CID's bit is set in the read list, and a write only if it is set in the write list. The transaction's secure flag must also equal the region's secure bit.
- R4: When the CID's bit is set in a region's privilege list, an unprivileged transaction from that CID is denied.
- R5: An enabled subregion that contains the address decides in place of its base region, and A wins over B. It grants only if the transaction CID equals the subregion CID, the secure flag matches, the privilege requirement is met, and the read or write bit for the direction is set.
- R6: Writes to start and end are dropped while the owning region or subregion is enabled. A start reads back with its low `GRAN_LOG2` bits zero, and an end with them all ones.
- R7: Writing a configuration word with bit0 = 0 clears only the enable. For a subregion, the lock bit is taken from the write and every other field is kept.
- R8: Setting control bit0 locks the global configuration until reset, and every region and subregion write is then dropped. The flags can still be cleared.
- R9: An unauthorized configuration write changes nothing. It sets the configuration-error flag and, if no flag is pending, captures its CID, secure and privileged flags with write = 1 and an address of 0.
- R10: When a subregion's delegation is enabled, the delegated CID may write that subregion's configuration, start and end, but not its delegation word.
- R11: A subregion lock, once set, stays set until reset and drops every write to that subregion.
- R12: Only the first event is captured while any flag is pending. Later violations still deny, but the capture stays unchanged. A trusted write of ones to the clear word clears the flags.
- R13: When several base regions contain the address, the lowest-indexed one decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_cid | input | 3 | Compartment ID of the configuration initiator |
| cfg_sec | input | 1 | Configuration initiator is secure |
| cfg_priv | input | 1 | Configuration initiator is privileged |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| chk_valid | input | 1 | Transaction present on the check port |
| chk_addr | input | ADDR_W | Transaction address |
| chk_cid | input | 3 | Transaction compartment ID |
| chk_sec | input | 1 | Transaction is secure |
| chk_priv | input | 1 | Transaction is privileged |
| chk_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Decision valid |
| res_grant | output | 1 | 1 = grant, 0 = deny |
| ill_flag | output | 1 | Illegal transaction recorded |
| cfg_err_flag | output | 1 | Rejected configuration write recorded |
| err_irq | output | 1 | Either flag set |

## Verification
The bench builds the block with `NUM_REGIONS = 3`, `ADDR_W = 20`, `GRAN_LOG2 = 8` and `TRUST_CID = 1`. With a 256-byte granule, the alignment forcing on start and end shows up in small, readable addresses. Three regions are enough to overlap two of them and test the lowest-index rule, while leaving one unused. Subregions A and B are placed inside region 0 so that both subregion priority and fall-back to the base rule can be reached.

// File: rtl/fw_pkg.sv
// Shared types and register word indices for the address firewall.
// Assumes 8 compartments (3-bit CID) and word-addressed configuration.
package fw_pkg;
    localparam int CID_W = 3;
    localparam int NCID  = 1 << CID_W;

    typedef struct packed {
        logic [CID_W-1:0] cid;
        logic             sec;
        logic             priv;
        logic             write;
    } fw_txn_t;

    // global block words
    localparam logic [3:0] G_CTRL = 4'd0;
    localparam logic [3:0] G_STAT = 4'd1;
    localparam logic [3:0] G_CLR  = 4'd2;
    localparam logic [3:0] G_INFO = 4'd3;
    localparam logic [3:0] G_ADDR = 4'd4;

    // base region words
    localparam logic [3:0] W_BCFG   = 4'd0;
    localparam logic [3:0] W_BSTART = 4'd1;
    localparam logic [3:0] W_BEND   = 4'd2;
    localparam logic [3:0] W_BLIST  = 4'd3;

    // subregion words (offset within the 4-word group)
    localparam logic [1:0] S_CFG   = 2'd0;
    localparam logic [1:0] S_START = 2'd1;
    localparam logic [1:0] S_END   = 2'd2;
    localparam logic [1:0] S_DLG   = 2'd3;
endpackage

// File: rtl/fw_subregion.sv
// One nested subregion: its registers, write authorization and match rule.
// Assumes the parent only uses hit/allow when its own base range matched.
module fw_subregion
    import fw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [1:0]        wr_word,
    input  logic [31:0]       wdata,
    input  logic              wr_trusted,
    input  logic [CID_W-1:0]  wr_cid,
    input  logic              glock,
    input  logic [1:0]        rd_word,
    output logic [31:0]       rdata,
    output logic              wr_denied,
    input  logic [ADDR_W-1:0] chk_addr,
    input  fw_txn_t           chk_txn,
    output logic              hit,
    output logic              allow
);
    localparam int HI_W = ADDR_W - GRAN_LOG2;

    logic              en_q, sec_q, priv_q, rd_q, wr_q, lock_q;
    logic [CID_W-1:0]  cid_q;
    logic [ADDR_W-1:0] start_q, end_q;
    logic              dlg_en_q;
    logic [CID_W-1:0]  dlg_cid_q;
    logic              wr_auth, wr_ok;

    // Who may write: trusted initiator, or the delegate except on the delegation word
    always_comb begin
        wr_auth   = wr_trusted ||
                    (dlg_en_q && (wr_cid == dlg_cid_q) && (wr_word != S_DLG));
        wr_denied = wr_sel && !wr_auth;
        wr_ok     = wr_sel && wr_auth && !glock && !lock_q;
    end

    // Register updates; bounds frozen while enabled, lock only set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            sec_q     <= 1'b0;
            priv_q    <= 1'b0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            lock_q    <= 1'b0;
            cid_q     <= '0;
            start_q   <= '0;
            end_q     <= '0;
            dlg_en_q  <= 1'b0;
            dlg_cid_q <= '0;
        end else if (wr_ok) begin
            case (wr_word)
                S_CFG: begin
                    en_q   <= wdata[0];
                    lock_q <= wdata[5];
                    if (wdata[0]) begin
                        sec_q  <= wdata[1];
                        priv_q <= wdata[2];
                        rd_q   <= wdata[3];
                        wr_q   <= wdata[4];
                        cid_q  <= wdata[8 +: CID_W];
                    end
                end
                S_START: if (!en_q) start_q <= {wdata[GRAN_LOG2 +: HI_W], {GRAN_LOG2{1'b0}}};
                S_END:   if (!en_q) end_q   <= {wdata[GRAN_LOG2 +: HI_W], {GRAN_LOG2{1'b1}}};
                default: begin
                    dlg_en_q  <= wdata[0];
                    dlg_cid_q <= wdata[4 +: CID_W];
                end
            endcase
        end
    end

    // Read-back formatting
    always_comb begin
        rdata = '0;
        case (rd_word)
            S_CFG: begin
                rdata[0]          = en_q;
                rdata[1]          = sec_q;
                rdata[2]          = priv_q;
                rdata[3]          = rd_q;
                rdata[4]          = wr_q;
                rdata[5]          = lock_q;
                rdata[8 +: CID_W] = cid_q;
            end
            S_START: rdata = 32'(start_q);
            S_END:   rdata = 32'(end_q);
            default: begin
                rdata[0]          = dlg_en_q;
                rdata[4 +: CID_W] = dlg_cid_q;
            end
        endcase
    end

    // Match and access rule
    always_comb begin
        hit   = en_q && (chk_addr >= start_q) && (chk_addr <= end_q);
        allow = (chk_txn.cid == cid_q) && (chk_txn.sec == sec_q) &&
                (!priv_q || chk_txn.priv) && (chk_txn.write ? wr_q : rd_q);
    end

    assert_sub_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> lock_q);
    assert_sub_bounds_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/fw_region.sv
// One base region with its two subregions; yields hit and allow for the
// presented transaction and handles its 16-word configuration block.
// Assumes subregion rules are only meaningful inside the base range.
module fw_region
    import fw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [3:0]        wr_word,
    input  logic [31:0]       wdata,
    input  logic              wr_trusted,
    input  logic [CID_W-1:0]  wr_cid,
    input  logic              glock,
    input  logic [3:0]        rd_word,
    output logic [31:0]       rdata,
    output logic              wr_denied,
    input  logic [ADDR_W-1:0] chk_addr,
    input  fw_txn_t           chk_txn,
    output logic              hit,
    output logic              allow
);
    localparam int HI_W  = ADDR_W - GRAN_LOG2;
    localparam int NSUB  = 2;

    logic              en_q, sec_q;
    logic [NCID-1:0]   plist_q, rlist_q, wlist_q;
    logic [ADDR_W-1:0] start_q, end_q;
    logic              base_grp, base_den, base_ok, base_allow;
    logic [NSUB-1:0]   sub_hit, sub_allow, sub_den;
    logic [31:0]       sub_rdata [NSUB];

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        fw_subregion #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_sub (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_sel && (wr_word[3:2] == 2'(s + 1))),
            .wr_word    (wr_word[1:0]),
            .wdata      (wdata),
            .wr_trusted (wr_trusted),
            .wr_cid     (wr_cid),
            .glock      (glock),
            .rd_word    (rd_word[1:0]),
            .rdata      (sub_rdata[s]),
            .wr_denied  (sub_den[s]),
            .chk_addr   (chk_addr),
            .chk_txn    (chk_txn),
            .hit        (sub_hit[s]),
            .allow      (sub_allow[s])
        );
    end

    // Base word authorization: trusted initiator only
    always_comb begin
        base_grp  = (wr_word[3:2] == 2'd0) || (wr_word[3:2] == 2'd3);
        base_den  = wr_sel && base_grp && !wr_trusted;
        base_ok   = wr_sel && base_grp && wr_trusted && !glock;
        wr_denied = base_den || (|sub_den);
    end

    // Base register updates; disable keeps the rest, bounds frozen while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            sec_q   <= 1'b0;
            plist_q <= '0;
            rlist_q <= '0;
            wlist_q <= '0;
            start_q <= '0;
            end_q   <= '0;
        end else if (base_ok) begin
            case (wr_word)
                W_BCFG: begin
                    en_q <= wdata[0];
                    if (wdata[0]) begin
                        sec_q   <= wdata[1];
                        plist_q <= wdata[8 +: NCID];
                    end
                end
                W_BSTART: if (!en_q) start_q <= {wdata[GRAN_LOG2 +: HI_W], {GRAN_LOG2{1'b0}}};
                W_BEND:   if (!en_q) end_q   <= {wdata[GRAN_LOG2 +: HI_W], {GRAN_LOG2{1'b1}}};
                W_BLIST: begin
                    rlist_q <= wdata[0 +: NCID];
                    wlist_q <= wdata[16 +: NCID];
                end
                default: ;
            endcase
        end
    end

    // Read-back formatting
    always_comb begin
        rdata = '0;
        if (rd_word[3:2] == 2'd1)      rdata = sub_rdata[0];
        else if (rd_word[3:2] == 2'd2) rdata = sub_rdata[1];
        else begin
            case (rd_word)
                W_BCFG: begin
                    rdata[0]         = en_q;
                    rdata[1]         = sec_q;
                    rdata[8 +: NCID] = plist_q;
                end
                W_BSTART: rdata = 32'(start_q);
                W_BEND:   rdata = 32'(end_q);
                W_BLIST: begin
                    rdata[0 +: NCID]  = rlist_q;
                    rdata[16 +: NCID] = wlist_q;
                end
                default: rdata = '0;
            endcase
        end
    end

    // Match and rule selection: subregion A, then B, then base
    always_comb begin
        hit        = en_q && (chk_addr >= start_q) && (chk_addr <= end_q);
        base_allow = (chk_txn.sec == sec_q) &&
                     (!plist_q[chk_txn.cid] || chk_txn.priv) &&
                     (chk_txn.write ? wlist_q[chk_txn.cid] : rlist_q[chk_txn.cid]);
        if (sub_hit[0])      allow = sub_allow[0];
        else if (sub_hit[1]) allow = sub_allow[1];
        else                 allow = base_allow;
    end

    assert_base_bounds_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/fw_capture.sv
// Error flags and first-event capture. A transaction violation wins over a
// configuration error in the same cycle; clears apply before new events.
module fw_capture
    import fw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol_ev,
    input  fw_txn_t           viol_txn,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              cerr_ev,
    input  fw_txn_t           cerr_txn,
    input  logic              clr_ev,
    input  logic [1:0]        clr_bits,
    output logic              ill_flag,
    output logic              cerr_flag,
    output fw_txn_t           cap_txn,
    output logic [ADDR_W-1:0] cap_addr
);
    logic ill_kept, cerr_kept;

    // Flags that survive this cycle's clear
    always_comb begin
        ill_kept  = ill_flag  && !(clr_ev && clr_bits[0]);
        cerr_kept = cerr_flag && !(clr_ev && clr_bits[1]);
    end

    // Flag update and capture of the first event only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ill_flag  <= 1'b0;
            cerr_flag <= 1'b0;
            cap_txn   <= '0;
            cap_addr  <= '0;
        end else begin
            ill_flag  <= ill_kept  || viol_ev;
            cerr_flag <= cerr_kept || cerr_ev;
            if (!ill_kept && !cerr_kept) begin
                if (viol_ev) begin
                    cap_txn  <= viol_txn;
                    cap_addr <= viol_addr;
                end else if (cerr_ev) begin
                    cap_txn  <= cerr_txn;
                    cap_addr <= '0;
                end
            end
        end
    end

    assert_capture_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ill_flag || cerr_flag) && !$past(clr_ev)) |-> ($stable(cap_txn) && $stable(cap_addr)));
    assert_cfg_err_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cerr_flag) && !ill_flag) |-> (cap_addr == '0));
endmodule

// File: rtl/addr_region_firewall.sv
// Top: configuration decode, global lock, region array with lowest-index
// priority, registered decision and error capture.
// Assumes NUM_REGIONS <= 15 (one 16-word block per region after the global block).
module addr_region_firewall
    import fw_pkg::*;
#(
    parameter int NUM_REGIONS = 15,
    parameter int ADDR_W      = 32,
    parameter int GRAN_LOG2   = 12,
    parameter int TRUST_CID   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [2:0]        cfg_cid,
    input  logic              cfg_sec,
    input  logic              cfg_priv,
    output logic [31:0]       cfg_rdata,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [2:0]        chk_cid,
    input  logic              chk_sec,
    input  logic              chk_priv,
    input  logic              chk_write,
    output logic              res_valid,
    output logic              res_grant,
    output logic              ill_flag,
    output logic              cfg_err_flag,
    output logic              err_irq
);
    localparam logic [CID_W-1:0] TCID = CID_W'(TRUST_CID);

    logic [3:0]             blk, word;
    logic                   trusted, glob_sel, glob_den, clr_ev, glock_q;
    logic                   grant_c, any_hit, viol_ev, cerr_ev;
    logic [NUM_REGIONS-1:0] reg_hit, reg_allow, reg_den;
    logic [31:0]            reg_rdata [NUM_REGIONS];
    fw_txn_t                chk_t, cfg_t, cap_txn;
    logic [ADDR_W-1:0]      cap_addr;

    // Decode of configuration access and initiator attributes
    always_comb begin
        blk      = cfg_addr[7:4];
        word     = cfg_addr[3:0];
        trusted  = cfg_sec && (cfg_cid == TCID);
        glob_sel = (blk == 4'd0);
        glob_den = cfg_wr_en && glob_sel && !trusted;
        clr_ev   = cfg_wr_en && glob_sel && trusted && (word == G_CLR);
        cerr_ev  = glob_den || (|reg_den);
        chk_t    = '{cid: chk_cid, sec: chk_sec, priv: chk_priv, write: chk_write};
        cfg_t    = '{cid: cfg_cid, sec: cfg_sec, priv: cfg_priv, write: 1'b1};
    end

    // Global lock: set-only until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            glock_q <= 1'b0;
        else if (cfg_wr_en && glob_sel && trusted && (word == G_CTRL) && cfg_wdata[0])
            glock_q <= 1'b1;
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        fw_region #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (cfg_wr_en && (blk == 4'(r + 1))),
            .wr_word    (word),
            .wdata      (cfg_wdata),
            .wr_trusted (trusted),
            .wr_cid     (cfg_cid),
            .glock      (glock_q),
            .rd_word    (word),
            .rdata      (reg_rdata[r]),
            .wr_denied  (reg_den[r]),
            .chk_addr   (chk_addr),
            .chk_txn    (chk_t),
            .hit        (reg_hit[r]),
            .allow      (reg_allow[r])
        );
    end

    // Lowest-indexed hitting region decides; no hit means deny
    always_comb begin
        grant_c = 1'b0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--)
            if (reg_hit[r]) grant_c = reg_allow[r];
        any_hit = |reg_hit;
        viol_ev = chk_valid && !grant_c;
    end

    // Registered decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_grant <= 1'b0;
        end else begin
            res_valid <= chk_valid;
            res_grant <= chk_valid && grant_c;
        end
    end

    fw_capture #(.ADDR_W(ADDR_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .viol_ev   (viol_ev),
        .viol_txn  (chk_t),
        .viol_addr (chk_addr),
        .cerr_ev   (cerr_ev),
        .cerr_txn  (cfg_t),
        .clr_ev    (clr_ev),
        .clr_bits  (cfg_wdata[1:0]),
        .ill_flag  (ill_flag),
        .cerr_flag (cfg_err_flag),
        .cap_txn   (cap_txn),
        .cap_addr  (cap_addr)
    );

    assign err_irq = ill_flag || cfg_err_flag;

    // Configuration read mux
    always_comb begin
        cfg_rdata = '0;
        if (glob_sel) begin
            case (word)
                G_CTRL: cfg_rdata[0] = glock_q;
                G_STAT: cfg_rdata[1:0] = {cfg_err_flag, ill_flag};
                G_INFO: begin
                    cfg_rdata[0 +: CID_W] = cap_txn.cid;
                    cfg_rdata[4]          = cap_txn.sec;
                    cfg_rdata[5]          = cap_txn.priv;
                    cfg_rdata[6]          = cap_txn.write;
                end
                G_ADDR: cfg_rdata = 32'(cap_addr);
                default: cfg_rdata = '0;
            endcase
        end else begin
            for (int r = 0; r < NUM_REGIONS; r++)
                if (blk == 4'(r + 1)) cfg_rdata = reg_rdata[r];
        end
    end

    assert_glock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(glock_q) |-> glock_q);
    assert_grant_needs_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_grant |-> $past(any_hit));
    assert_grant_only_when_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_grant |-> res_valid);
endmodule

// File: tb/test_addr_region_firewall.sv
module test_addr_region_firewall;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [2:0]    cfg_cid = '0;
    logic          cfg_sec = 1'b0;
    logic          cfg_priv = 1'b0;
    logic [31:0]   cfg_rdata;
    logic          chk_valid = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic [2:0]    chk_cid = '0;
    logic          chk_sec = 1'b0;
    logic          chk_priv = 1'b0;
    logic          chk_write = 1'b0;
    logic          res_valid, res_grant, ill_flag, cfg_err_flag, err_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    addr_region_firewall #(.NUM_REGIONS(3), .ADDR_W(AW), .GRAN_LOG2(8), .TRUST_CID(1))
        i_addr_region_firewall (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_cid(cfg_cid), .cfg_sec(cfg_sec), .cfg_priv(cfg_priv),
        .cfg_rdata(cfg_rdata), .chk_valid(chk_valid), .chk_addr(chk_addr),
        .chk_cid(chk_cid), .chk_sec(chk_sec), .chk_priv(chk_priv), .chk_write(chk_write),
        .res_valid(res_valid), .res_grant(res_grant), .ill_flag(ill_flag),
        .cfg_err_flag(cfg_err_flag), .err_irq(err_irq)
    );

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [2:0] c, input logic s);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_cid = c; cfg_sec = s;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic twrite(input logic [7:0] a, input logic [31:0] d);
        cfg_write(a, d, 3'd1, 1'b1);
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        cfg_read(a, d);
        expect32(tag, d, exp);
    endtask

    task automatic do_check(input string tag, input logic [AW-1:0] a, input logic [2:0] c,
                            input logic s, input logic p, input logic w, input logic exp);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; chk_cid = c; chk_sec = s; chk_priv = p; chk_write = w;
        @(negedge clk);
        chk_valid = 1'b0;
        expect32({tag, " R2 valid"}, 32'(res_valid), 32'd1);
        expect32(tag, 32'(res_grant), 32'(exp));
        @(negedge clk);
        expect32({tag, " R2 idle"}, 32'(res_valid), 32'd0);
    endtask

    task automatic clear_flags();
        twrite(8'h02, 32'h3);
    endtask

    task automatic t_reset();
        expect_reg("R1 status after reset", 8'h01, 32'h0);
        expect_reg("R1 lock after reset", 8'h00, 32'h0);
        do_check("R1 no region denies", 20'h00123, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_reg("R12 illegal flag set", 8'h01, 32'h1);
        expect_reg("R12 info captured", 8'h03, 32'h12);
        expect_reg("R12 addr captured", 8'h04, 32'h00123);
        do_check("R12 later violation denied", 20'h00456, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_reg("R12 info kept", 8'h03, 32'h12);
        expect_reg("R12 addr kept", 8'h04, 32'h00123);
        clear_flags();
        expect_reg("R12 flags cleared", 8'h01, 32'h0);
    endtask

    task automatic t_base();
        twrite(8'h11, 32'h1000);
        twrite(8'h12, 32'h1F00);
        twrite(8'h13, 32'h00020006);
        twrite(8'h10, 32'h403);
        expect_reg("R6 end low bits ones", 8'h12, 32'h1FFF);
        do_check("R3 listed read", 20'h01800, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        do_check("R4 unprivileged denied", 20'h01800, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        do_check("R4 privileged granted", 20'h01800, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1);
        do_check("R3 write not listed", 20'h01800, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0);
        do_check("R3 write listed", 20'h01800, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1);
        do_check("R3 secure mismatch", 20'h01800, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        do_check("R1 outside region", 20'h02000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        clear_flags();
    endtask

    task automatic t_freeze();
        twrite(8'h11, 32'h0);
        expect_reg("R6 start frozen", 8'h11, 32'h1000);
        twrite(8'h10, 32'h0);
        expect_reg("R7 disable keeps config", 8'h10, 32'h402);
        do_check("R7 disabled denies", 20'h01800, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        twrite(8'h11, 32'h08FF);
        expect_reg("R6 start aligned when free", 8'h11, 32'h0800);
        twrite(8'h11, 32'h1000);
        twrite(8'h10, 32'h403);
        do_check("R7 re-enabled grants", 20'h01800, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        clear_flags();
    endtask

    task automatic t_sub();
        twrite(8'h15, 32'h1000);
        twrite(8'h16, 32'h1000);
        twrite(8'h14, 32'h31B);
        do_check("R5 sub A grants its CID", 20'h01080, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1);
        do_check("R5 sub A overrides base", 20'h01080, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        do_check("R5 base outside sub", 20'h01180, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        twrite(8'h19, 32'h1000);
        twrite(8'h1A, 32'h1100);
        twrite(8'h18, 32'h40B);
        do_check("R5 A wins over B", 20'h01080, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1);
        do_check("R5 sub B read", 20'h01180, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1);
        do_check("R5 sub B no write", 20'h01180, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0);
        do_check("R5 sub B secure mismatch", 20'h01180, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
        clear_flags();
    endtask

    task automatic t_deleg();
        cfg_write(8'h11, 32'h0, 3'd2, 1'b1);
        expect_reg("R9 cfg error flag", 8'h01, 32'h2);
        expect_reg("R9 cfg error info", 8'h03, 32'h52);
        expect_reg("R9 cfg error addr zero", 8'h04, 32'h0);
        expect_reg("R9 rejected write no effect", 8'h11, 32'h1000);
        clear_flags();
        twrite(8'h1B, 32'h61);
        expect_reg("R10 delegation word", 8'h1B, 32'h61);
        cfg_write(8'h18, 32'h0, 3'd6, 1'b0);
        expect_reg("R10 delegate disabled sub B", 8'h18, 32'h40A);
        expect_reg("R10 delegate write no error", 8'h01, 32'h0);
        cfg_write(8'h1B, 32'h0, 3'd6, 1'b0);
        expect_reg("R10 delegate cannot redelegate", 8'h01, 32'h2);
        expect_reg("R10 delegation unchanged", 8'h1B, 32'h61);
        clear_flags();
    endtask

    task automatic t_lock();
        twrite(8'h18, 32'h20);
        expect_reg("R11 lock set", 8'h18, 32'h42A);
        twrite(8'h18, 32'h40B);
        expect_reg("R11 locked cfg dropped", 8'h18, 32'h42A);
        cfg_write(8'h19, 32'h0, 3'd6, 1'b0);
        expect_reg("R11 locked start dropped", 8'h19, 32'h1000);
        expect_reg("R11 locked drop no error", 8'h01, 32'h0);
        do_check("R11 falls back to base", 20'h01180, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
        clear_flags();
    endtask

    task automatic t_prio();
        twrite(8'h21, 32'h1000);
        twrite(8'h22, 32'h3F00);
        twrite(8'h23, 32'h00FF00FF);
        twrite(8'h20, 32'h1);
        do_check("R13 second region alone", 20'h03000, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1);
        do_check("R13 lower index decides", 20'h01800, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        clear_flags();
    endtask

    task automatic t_glock();
        twrite(8'h00, 32'h1);
        expect_reg("R8 lock reads set", 8'h00, 32'h1);
        twrite(8'h20, 32'h0);
        expect_reg("R8 region write dropped", 8'h20, 32'h1);
        do_check("R8 region still grants", 20'h03000, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1);
        do_check("R8 violation", 20'h08000, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_reg("R8 flag before clear", 8'h01, 32'h1);
        clear_flags();
        expect_reg("R8 clear works when locked", 8'h01, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_freeze();
        t_sub();
        t_deleg();
        t_lock();
        t_prio();
        t_glock();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule